// File: doc/BRIEF.md
# FIFO-buffered SPI master with register port

This block is a serial peripheral master that a processor drives through a small 32-bit register window. Software queues words in a transmit FIFO, sets the clock mode, the bit order and the slave-select pattern, and then lets the shift engine run. Every word shifted out on the data-out line returns a word sampled from the data-in line, and that word lands in a receive FIFO for software to collect.

Software can hold off the serial clock with an inhibit bit. It can fill the transmit FIFO while the bit is set and then release the whole burst at once. Slave select comes straight from a register. In manual mode the register pattern stays on the pins the whole time. In automatic mode it appears on the pins only while a word is being shifted, and the pins return to all ones for at least one clock between words. The word width, the FIFO depth (a power of two), the serial clock divider and the number of selects are build-time parameters. Interrupt collection is done elsewhere; this block gives it only a one-cycle receive-overrun pulse.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, control reads 0x100 (transmit inhibited), the select register reads all ones, status reads 0x05 (RX empty, TX empty), `sclk` is 0 and `ss_n` is all ones.
- R2: Registers sit at byte addresses 0x60 control, 0x64 status, 0x68 transmit data (write), 0x6C receive data (read) and 0x70 slave select. Other addresses read 0. Control bits are 1 enable, 2 master, 3 clock idle level, 4 clock phase, 5 TX flush, 6 RX flush, 7 manual select, 8 transmit inhibit and 9 LSB first. Status bits are 0 RX empty, 1 RX full, 2 TX empty, 3 TX full and 4 mode fault (always 0).
- R3: A write to 0x68 appends the low WORD_W bits to the TX FIFO. TX full is set at DEPTH words, and a write while the FIFO is full is ignored.
- R4: A word is started only while enable and master are 1 and inhibit is 0. While inhibit is 1 no new word starts, so the serial clock does not move even with words queued. Clearing inhibit starts the queued words in order.
- R5: Each bit takes two half periods of HALF_DIV clocks. `sclk` equals the control clock idle level when idle. With phase 0 it goes active in the second half of every bit; with phase 1 it goes active in the first half. `miso` is sampled at the start of each bit's second half.
- R6: With LSB first set, bit 0 leaves first; otherwise bit WORD_W-1 leaves first. Received bits are placed using the same order.
- R7: With manual select set, `ss_n` equals the select register at all times. Otherwise `ss_n` equals the register only while a word is shifting and is all ones otherwise.
- R8: Each finished word is pushed into the RX FIFO. A read of 0x6C returns the oldest word and removes it. A read of 0x6C while the FIFO is empty returns 0.
- R9: A word that finishes while the RX FIFO is full is dropped, and `rx_overrun` pulses for one cycle. If a read pops the FIFO in that same cycle, the word is kept and no pulse occurs.
- R10: Writing control with bit 5 or bit 6 set empties the TX or RX FIFO in that cycle, and this wins over a push in the same cycle. Both bits read back 0.
- R11: TX empty is 1 only when the TX FIFO holds nothing and no word is still shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops RX data at 0x6C) |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address (combinational) |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NSS | Active-low slave selects |
| rx_overrun | output | 1 | One-cycle pulse when a received word is dropped |

## Verification
In one clock edge, the engine can push a finished word into a full receive FIFO while software pops that same FIFO. The bench provokes this by filling the FIFO to depth and sending one more word. It then issues a single data read timed to land on the exact completion edge, counted from the transmit write. The result is judged by the absence of an overrun pulse, by the popped value being the oldest word, and by the new word arriving last among the DEPTH words that remain. A behavioural model also compares the pins and the read data on every clock.

// File: rtl/spi_fifo_master.sv
module spi_fifo_master #(
  parameter int WORD_W   = 8,
  parameter int DEPTH    = 16,
  parameter int HALF_DIV = 2,
  parameter int NSS      = 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NSS-1:0]    ss_n,
  output logic              rx_overrun
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int SW = $clog2(2 * WORD_W);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [9:0]    CTRL_MASK = 10'h39E;
  localparam logic [9:0]    CTRL_RST  = 10'h100;
  localparam logic [SW-1:0] LAST_SLOT = SW'(2 * WORD_W - 1);
  localparam logic [DW-1:0] LAST_DIV  = DW'(HALF_DIV - 1);
  localparam logic [CW-1:0] FULL_CNT  = CW'(DEPTH);

  logic [9:0]        ctrl;
  logic [NSS-1:0]    ssr;
  logic [WORD_W-1:0] tx_mem [DEPTH];
  logic [WORD_W-1:0] rx_mem [DEPTH];
  logic [AW-1:0]     tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0]     tx_cnt, rx_cnt;
  logic              active;
  logic [SW-1:0]     slot;
  logic [DW-1:0]     div;
  logic [WORD_W-1:0] txsh, rxsh;

  wire wr_ctrl = bus_wr && bus_addr == 8'h60;
  wire tx_rst  = wr_ctrl && bus_wdata[5];
  wire rx_rst  = wr_ctrl && bus_wdata[6];
  wire tx_full = tx_cnt == FULL_CNT;
  wire rx_full = rx_cnt == FULL_CNT;
  wire lsb     = ctrl[9];
  wire push_tx = bus_wr && bus_addr == 8'h68 && !tx_full && !tx_rst;
  wire start   = !active && ctrl[1] && ctrl[2] && !ctrl[8] && tx_cnt != '0 && !tx_rst;
  wire pop_rx  = bus_rd && bus_addr == 8'h6C && rx_cnt != '0 && !rx_rst;
  wire tick    = active && div == LAST_DIV;
  wire last    = tick && slot == LAST_SLOT;
  wire push_rx = last && !rx_rst && (!rx_full || pop_rx);

  assign sclk = ctrl[3] ^ (active & (slot[0] ^ ctrl[4]));
  assign mosi = active & (lsb ? txsh[0] : txsh[WORD_W-1]);
  assign ss_n = (ctrl[7] || active) ? ssr : '1;

  always_comb begin
    case (bus_addr)
      8'h60:   bus_rdata = {22'b0, ctrl};
      8'h64:   bus_rdata = {27'b0, 1'b0, tx_full, tx_cnt == '0 && !active, rx_full, rx_cnt == '0};
      8'h6C:   bus_rdata = (rx_cnt != '0) ? 32'(rx_mem[rx_rp]) : 32'b0;
      8'h70:   bus_rdata = 32'(ssr);
      default: bus_rdata = 32'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl <= CTRL_RST;
      ssr  <= '1;
      rx_overrun <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= bus_wdata[9:0] & CTRL_MASK;
      if (bus_wr && bus_addr == 8'h70) ssr <= bus_wdata[NSS-1:0];
      rx_overrun <= last && !rx_rst && rx_full && !pop_rx;
    end

  always_ff @(posedge clk) begin
    if (push_tx) tx_mem[tx_wp] <= bus_wdata[WORD_W-1:0];
    if (push_rx) rx_mem[rx_wp] <= rxsh;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (tx_rst) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (push_tx) tx_wp <= tx_wp + 1'b1;
      if (start)   tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(push_tx) - CW'(start);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (rx_rst) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (push_rx) rx_wp <= rx_wp + 1'b1;
      if (pop_rx)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(push_rx) - CW'(pop_rx);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active <= 1'b0; slot <= '0; div <= '0; txsh <= '0; rxsh <= '0;
    end else if (start) begin
      active <= 1'b1; slot <= '0; div <= '0;
      txsh   <= tx_mem[tx_rp];
    end else if (tick) begin
      div <= '0;
      if (slot == LAST_SLOT) active <= 1'b0;
      else begin
        slot <= slot + 1'b1;
        if (!slot[0]) rxsh <= lsb ? {miso, rxsh[WORD_W-1:1]} : {rxsh[WORD_W-2:0], miso};
        else          txsh <= lsb ? (txsh >> 1) : (txsh << 1);
      end
    end else if (active) begin
      div <= div + 1'b1;
    end
endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk #(
  parameter int DEPTH = 16,
  parameter int NSS   = 4,
  parameter int CW    = 5
)(
  input logic           clk,
  input logic           rst_n,
  input logic           bus_wr,
  input logic [7:0]     bus_addr,
  input logic [31:0]    bus_wdata,
  input logic [31:0]    bus_rdata,
  input logic           sclk,
  input logic [NSS-1:0] ss_n,
  input logic           rx_overrun,
  input logic           active,
  input logic [9:0]     ctrl,
  input logic [CW-1:0]  tx_cnt,
  input logic [CW-1:0]  rx_cnt
);
  p_tx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n) tx_cnt <= CW'(DEPTH));
  p_rx_bound_r8: assert property (@(posedge clk) disable iff (!rst_n) rx_cnt <= CW'(DEPTH));
  p_full_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h68 && tx_cnt == CW'(DEPTH) && ctrl[8]) |=> tx_cnt == CW'(DEPTH));
  p_inhibit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[8] && !active) |=> !active);
  p_idle_sclk_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> sclk == ctrl[3]);
  p_auto_ss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[7] && !active) |-> ss_n == '1);
  p_ovr_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |-> rx_cnt == CW'(DEPTH));
  p_rxflush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h60 && bus_wdata[6]) |=> rx_cnt == '0);
  p_txflush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h60 && bus_wdata[5]) |=> tx_cnt == '0);
  p_selfclr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == 8'h60 |-> bus_rdata[6:5] == 2'b00);
endmodule

bind spi_fifo_master spi_fifo_master_chk #(.DEPTH(DEPTH), .NSS(NSS), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .sclk(sclk), .ss_n(ss_n), .rx_overrun(rx_overrun),
  .active(active), .ctrl(ctrl), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/spi_fifo_master_tb.sv
`timescale 1ns/1ps
module spi_fifo_master_tb;
  localparam int W = 8, DEPTH = 16, HALF = 2, NSS = 4;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic sclk, mosi, miso, rx_overrun, flip = 0;
  logic [NSS-1:0] ss_n;

  assign miso = mosi ^ flip;
  always #5 clk = ~clk;

  spi_fifo_master #(.WORD_W(W), .DEPTH(DEPTH), .HALF_DIV(HALF), .NSS(NSS)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi), .miso(miso),
    .ss_n(ss_n), .rx_overrun(rx_overrun));

  int total = 0, bad = 0, cyc = 0, ovr_cnt = 0, edges = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // behavioural reference model
  logic [9:0] m_ctrl = 10'h100;
  logic [NSS-1:0] m_ssr = '1;
  logic [W-1:0] txq[$], rxq[$];
  logic [W-1:0] m_txw = 0, m_rxw = 0;
  bit m_busy = 0, m_ovr = 0;
  int m_slot = 0, m_div = 0;

  always @(posedge clk) begin
    bit wc, txr, rxr, txf, rxf, st, popr, tk, lst;
    if (!rst_n) begin
      m_ctrl = 10'h100; m_ssr = '1; txq.delete(); rxq.delete();
      m_busy = 0; m_slot = 0; m_div = 0; m_ovr = 0;
    end else begin
      wc   = bus_wr && bus_addr == 8'h60;
      txr  = wc && bus_wdata[5];
      rxr  = wc && bus_wdata[6];
      txf  = txq.size() >= DEPTH;
      rxf  = rxq.size() >= DEPTH;
      st   = !m_busy && m_ctrl[1] && m_ctrl[2] && !m_ctrl[8] && txq.size() > 0 && !txr;
      popr = bus_rd && bus_addr == 8'h6C && rxq.size() > 0 && !rxr;
      tk   = m_busy && m_div == HALF - 1;
      lst  = tk && m_slot == 2 * W - 1;
      m_ovr = lst && !rxr && rxf && !popr;
      if (popr) void'(rxq.pop_front());
      if (rxr) rxq.delete();
      else if (lst && (!rxf || popr)) rxq.push_back(m_rxw);
      if (st) begin
        m_txw = txq.pop_front(); m_busy = 1; m_slot = 0; m_div = 0;
      end else if (tk) begin
        m_div = 0;
        if (m_slot == 2 * W - 1) m_busy = 0;
        else begin
          m_slot++;
          if (m_slot % 2 == 1) m_rxw[m_ctrl[9] ? m_slot / 2 : W - 1 - m_slot / 2] = miso;
        end
      end else if (m_busy) m_div++;
      if (txr) txq.delete();
      else if (bus_wr && bus_addr == 8'h68 && !txf) txq.push_back(bus_wdata[W-1:0]);
      if (wc) m_ctrl = bus_wdata[9:0] & 10'h39E;
      if (bus_wr && bus_addr == 8'h70) m_ssr = bus_wdata[NSS-1:0];
    end
  end

  function automatic logic [31:0] m_rdata(logic [7:0] a);
    case (a)
      8'h60: return {22'b0, m_ctrl};
      8'h64: return {27'b0, 1'b0, txq.size() == DEPTH, txq.size() == 0 && !m_busy,
                     rxq.size() == DEPTH, rxq.size() == 0};
      8'h6C: return rxq.size() > 0 ? 32'(rxq[0]) : 32'b0;
      8'h70: return 32'(m_ssr);
      default: return 32'b0;
    endcase
  endfunction

  always @(negedge clk) if (rst_n) begin
    logic e_sclk, e_mosi;
    logic [NSS-1:0] e_ss;
    int j;
    j = m_slot / 2;
    e_sclk = m_ctrl[3] ^ (m_busy && ((m_slot % 2) != int'(m_ctrl[4])));
    e_mosi = m_busy ? m_txw[m_ctrl[9] ? j : W - 1 - j] : 1'b0;
    e_ss   = (m_ctrl[7] || m_busy) ? m_ssr : '1;
    if (sclk !== e_sclk)      chk("R5 sclk", 32'(sclk), 32'(e_sclk));
    if (mosi !== e_mosi)      chk("R6 mosi", 32'(mosi), 32'(e_mosi));
    if (ss_n !== e_ss)        chk("R7 ss_n", 32'(ss_n), 32'(e_ss));
    if (rx_overrun !== m_ovr) chk("R9 overrun", 32'(rx_overrun), 32'(m_ovr));
    if (bus_rdata !== m_rdata(bus_addr))
      chk(bus_addr == 8'h64 ? "R11 status" : bus_addr == 8'h6C ? "R8 rxdata" : "R2 rdata",
          bus_rdata, m_rdata(bus_addr));
    total++;
  end

  always @(posedge clk) begin
    cyc++;
    if (rst_n && rx_overrun) ovr_cnt++;
    if (cyc == 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      summary();
    end
  end
  always @(posedge sclk) edges++;

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1; bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(posedge clk); #1; bus_rd = 1; bus_addr = a;
    @(negedge clk); d = bus_rdata;
    @(posedge clk); #1; bus_rd = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(8'h64, s);
      if (s[2]) return;
    end
  endtask

  logic [31:0] v;
  initial begin
    repeat (3) @(posedge clk); #1 rst_n = 1;
    // R1 reset state
    rd(8'h60, v); chk("R1 ctrl", v, 32'h100);
    rd(8'h64, v); chk("R1 status", v, 32'h05);
    rd(8'h70, v); chk("R1 ssr", v, 32'hF);
    chk("R1 ss_n", 32'(ss_n), 32'hF);
    chk("R1 sclk", 32'(sclk), 0);
    rd(8'h40, v); chk("R2 unmapped", v, 0);
    rd(8'h6C, v); chk("R8 empty read", v, 0);

    // R4 preload under inhibit
    wr(8'h60, 32'h106);
    wr(8'h68, 32'hA5); wr(8'h68, 32'h3C); wr(8'h68, 32'h81);
    edges = 0;
    repeat (40) @(posedge clk);
    chk("R4 no sclk while inhibited", edges, 0);
    rd(8'h64, v); chk("R11 tx not empty", v, 32'h01);
    wr(8'h70, 32'hB);
    wr(8'h60, 32'h006);
    repeat (2) @(posedge clk); @(negedge clk);
    chk("R7 auto select during word", 32'(ss_n), 32'hB);
    wait_idle();
    chk("R5 clock edges", edges, 24);
    chk("R7 auto select idle", 32'(ss_n), 32'hF);
    rd(8'h6C, v); chk("R8 rx0", v, 32'hA5);
    rd(8'h6C, v); chk("R8 rx1", v, 32'h3C);
    rd(8'h6C, v); chk("R8 rx2", v, 32'h81);

    // R5 R6 R7 mode 3, LSB first, manual select, inverted return
    flip = 1;
    wr(8'h60, 32'h29E);
    repeat (2) @(posedge clk); @(negedge clk);
    chk("R5 idle level high", 32'(sclk), 1);
    chk("R7 manual select idle", 32'(ss_n), 32'hB);
    wr(8'h68, 32'h5A); wr(8'h68, 32'h01);
    wait_idle();
    rd(8'h6C, v); chk("R6 lsb rx0", v, 32'hA5);
    rd(8'h6C, v); chk("R6 lsb rx1", v, 32'hFE);
    flip = 0;

    // R10 TX flush
    wr(8'h60, 32'h106);
    wr(8'h68, 32'h11); wr(8'h68, 32'h22);
    wr(8'h60, 32'h126);
    rd(8'h64, v); chk("R10 tx flushed", v, 32'h05);
    rd(8'h60, v); chk("R10 self clear", v, 32'h106);
    edges = 0;
    wr(8'h60, 32'h006);
    repeat (40) @(posedge clk);
    chk("R10 nothing sent", edges, 0);

    // R3 full ignore, R9 overrun
    wr(8'h60, 32'h106);
    for (int i = 0; i < 16; i++) wr(8'h68, 32'h10 + i);
    rd(8'h64, v); chk("R3 tx full", v, 32'h09);
    wr(8'h68, 32'hEE);
    wr(8'h60, 32'h006);
    repeat (60) @(posedge clk);
    wr(8'h68, 32'h20);
    wait_idle();
    chk("R9 one overrun", ovr_cnt, 1);
    rd(8'h64, v); chk("R9 rx full", v, 32'h06);

    // R9 pop and push in the same cycle
    wr(8'h68, 32'h77);
    repeat (31) @(posedge clk);
    rd(8'h6C, v); chk("R9 pop on completion edge", v, 32'h10);
    wait_idle();
    chk("R9 no second overrun", ovr_cnt, 1);
    for (int i = 1; i < 16; i++) begin
      rd(8'h6C, v); chk("R3 rx order", v, 32'h10 + i);
    end
    rd(8'h6C, v); chk("R9 kept word", v, 32'h77);

    // R10 RX flush
    wr(8'h68, 32'h33); wr(8'h68, 32'h44);
    wait_idle();
    wr(8'h60, 32'h046);
    rd(8'h64, v); chk("R10 rx flushed", v, 32'h05);
    rd(8'h6C, v); chk("R8 read after flush", v, 0);
    summary();
  end
endmodule